// File: doc/BRIEF.md
# Supervisory Reset Timing Controller

This block turns three reset requests into one stretched reset. The requests are a supply-good level from an external comparator, a manual-reset pushbutton that is active low, and a shared active-low reset pin that is open drain. The reset is presented on two outputs, one active high and one active low, and on a write-inhibit level for the memory beside the block. The supply and button inputs pass through a synchronizer and a glitch filter. A low level must persist for a parameterised number of cycles before it counts.

Once every request has cleared, the reset is held for a further `TIMEOUT_CYC` cycles. The supply and the button are level requests: reset lasts as long as they are low, then the timeout follows. The shared pin is an edge request. A falling edge that some other device drives onto it starts a full timeout, even when the external pulse is short. The block drives the pin low itself whenever reset is active. It recognises the low it causes by aligning its own drive enable with the synchronized pin level, so its own drive never retriggers it. All timing is counted in system clock cycles.

Top module: `reset_supervisor`

## Requirements
- R1: While `rst_ni` is low, `rst_o`=1, `rst_no`=0, `wr_inhibit_o`=1 and `pin_drive_o`=1. After `rst_ni` rises with the supply good, reset stays active until the filter and timeout have elapsed.
- R2: A supply-good low that lasts at least `SUPPLY_FILT_CYC` cycles asserts reset at the `SYNC_STAGES+SUPPLY_FILT_CYC`-th rising edge after the input changes. Edges are counted from 0, starting with the first edge that samples the change.
- R3: A supply-good low shorter than `SUPPLY_FILT_CYC` cycles leaves every output unchanged.
- R4: Reset stays active while the filtered supply is low. It is released at edge `SYNC_STAGES-1+SUPPLY_FILT_CYC+TIMEOUT_CYC` after the supply input returns high.
- R5: Reset is active while the button is held low, and is released at edge `SYNC_STAGES-1+MR_FILT_CYC+TIMEOUT_CYC` after the button returns high.
- R6: A button low shorter than `MR_FILT_CYC` cycles leaves every output unchanged.
- R7: An external falling edge on the pin, seen while the block is not driving it, asserts reset at edge `SYNC_STAGES`. Reset is then released at edge `SYNC_STAGES+TIMEOUT_CYC`, even for a pulse much shorter than the timeout.
- R8: The low the block drives on the pin itself never starts a new timeout. Once the pin is released, reset stays inactive.
- R9: `rst_no` is always the complement of `rst_o`.
- R10: `wr_inhibit_o` and `pin_drive_o` always equal `rst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the logic |
| supply_ok_i | input | 1 | Comparator output, 1 = supply above threshold (asynchronous) |
| mr_ni | input | 1 | Manual-reset button, active low (asynchronous) |
| rst_pin_i | input | 1 | Sampled level of the shared active-low reset pin |
| pin_drive_o | output | 1 | 1 = pull the shared pin low |
| rst_o | output | 1 | Reset, active high |
| rst_no | output | 1 | Reset, active low |
| wr_inhibit_o | output | 1 | Memory write inhibit, 1 = writes blocked |

## Verification
The bench builds the block with two synchronizer stages, a supply filter of 4 cycles, a button filter of 3 cycles and a timeout of 40 cycles. These values make the glitch thresholds one cycle apart and the release edges of all three sources exact within a short run. The short timeout also lets the random phase see many complete assert and release cycles, including external pin pulses that overlap the block's own drive. Supply and button values this small would not be used in silicon. They keep the same off-by-one boundaries as the defaults.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef struct packed {
    logic supply_ok;
    logic mr_n;
    logic pin_edge;
  } rsv_req_t;

  function automatic logic rsv_hold(input rsv_req_t r);
    return ~r.supply_ok | ~r.mr_n;
  endfunction
endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= INIT;
        else         ff_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= {STAGES{INIT}};
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/rsv_glitch_filter.sv
module rsv_glitch_filter #(
  parameter int   SYNC_STAGES = 2,
  parameter int   FILT_CYC    = 4,
  parameter logic INIT        = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic          s;
  logic [CW-1:0] cnt_q;

  rsv_sync #(.STAGES(SYNC_STAGES), .INIT(INIT)) u_sync (
    .clk_i, .rst_ni, .d_i, .q_o(s)
  );

  // q follows s only after s has differed for FILT_CYC consecutive edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= INIT;
      cnt_q <= '0;
    end else if (s == q_o) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(FILT_CYC - 1)) begin
      q_o   <= s;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rsv_pin_edge.sv
module rsv_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic drive_i,
  output logic edge_o
);
  logic pin_s, drive_s, ext_low, ext_low_q;

  rsv_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_pin_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pin_s)
  );

  // drive enable delayed to line up with the synchronized pin level
  rsv_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_drive_dly (
    .clk_i, .rst_ni, .d_i(drive_i), .q_o(drive_s)
  );

  assign ext_low = ~pin_s & ~drive_s;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ext_low_q <= 1'b0;
    else         ext_low_q <= ext_low;

  assign edge_o = ext_low & ~ext_low_q;
endmodule

// File: rtl/rsv_timer.sv
module rsv_timer #(
  parameter int TIMEOUT_CYC = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  rsv_pkg::rsv_req_t req_i,
  output logic active_o
);
  localparam int CW = $clog2(TIMEOUT_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b1;
      cnt_q    <= '0;
    end else if (rsv_pkg::rsv_hold(req_i) || req_i.pin_edge) begin
      active_o <= 1'b1;
      cnt_q    <= '0;
    end else if (active_o) begin
      if (cnt_q == CW'(TIMEOUT_CYC - 1)) begin
        active_o <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor #(
  parameter int SYNC_STAGES     = 2,
  parameter int SUPPLY_FILT_CYC = 8,
  parameter int MR_FILT_CYC     = 8,
  parameter int TIMEOUT_CYC     = 10_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic mr_ni,
  input  logic rst_pin_i,
  output logic pin_drive_o,
  output logic rst_o,
  output logic rst_no,
  output logic wr_inhibit_o
);
  import rsv_pkg::*;

  logic     supply_ok_f, mr_n_f, pin_edge, rst_act;
  rsv_req_t req;

  rsv_glitch_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYC(SUPPLY_FILT_CYC), .INIT(1'b0))
    u_supply_filt (.clk_i, .rst_ni, .d_i(supply_ok_i), .q_o(supply_ok_f));

  rsv_glitch_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYC(MR_FILT_CYC), .INIT(1'b1))
    u_mr_filt (.clk_i, .rst_ni, .d_i(mr_ni), .q_o(mr_n_f));

  rsv_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin_edge (
    .clk_i, .rst_ni, .pin_i(rst_pin_i), .drive_i(rst_act), .edge_o(pin_edge)
  );

  assign req = '{supply_ok: supply_ok_f, mr_n: mr_n_f, pin_edge: pin_edge};

  rsv_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i, .rst_ni, .req_i(req), .active_o(rst_act)
  );

  assign rst_o        = rst_act;
  assign rst_no       = ~rst_act;
  assign wr_inhibit_o = rst_act;
  assign pin_drive_o  = rst_act;
endmodule

// File: rtl/reset_supervisor_chk.sv
module reset_supervisor_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic supply_ok_f,
  input logic mr_n_f,
  input logic pin_edge,
  input logic rst_o,
  input logic rst_no
);
  p_supply_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_f |=> rst_o);

  p_mr_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mr_n_f |=> rst_o);

  p_pin_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_edge |=> (rst_o && !rst_no));

  p_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_o) |-> ($past(supply_ok_f) && $past(mr_n_f) && !$past(pin_edge)));
endmodule

bind reset_supervisor reset_supervisor_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .supply_ok_f(supply_ok_f), .mr_n_f(mr_n_f),
  .pin_edge(pin_edge), .rst_o(rst_o), .rst_no(rst_no)
);

// File: tb/tb_reset_supervisor.sv
module tb_reset_supervisor;
  localparam int NS = 2, SF = 4, MF = 3, T = 40;
  localparam int FMAX = (SF > MF) ? SF : MF;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic supply_ok = 1'b1, mr_n = 1'b1, ext_low = 1'b0;
  logic pin, pin_drive, rst_o, rst_no, wr_inh;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;
  assign pin = (pin_drive | ext_low) ? 1'b0 : 1'b1;

  reset_supervisor #(.SYNC_STAGES(NS), .SUPPLY_FILT_CYC(SF), .MR_FILT_CYC(MF), .TIMEOUT_CYC(T)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .supply_ok_i(supply_ok), .mr_ni(mr_n),
    .rst_pin_i(pin), .pin_drive_o(pin_drive), .rst_o(rst_o), .rst_no(rst_no),
    .wr_inhibit_o(wr_inh)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic links();
    chk("R9 complement", rst_no, ~rst_o);
    chk("R10 inhibit", wr_inh, rst_o);
    chk("R10 pin drive", pin_drive, rst_o);
  endtask

  // advance to the sample point just after the next n rising edges
  task automatic steps(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      links();
    end
  endtask

  function automatic logic exp_by_run(input int run, input int lim, input logic prev);
    return (run >= lim) ? 1'b1 : prev;
  endfunction

  initial begin
    int s_run, m_run, idle_run, s_rem, m_rem, p_rem;
    logic e;
    void'($urandom(32'd4711));
    steps(3);
    chk("R1 rst_o in reset", rst_o, 1'b1);
    chk("R1 rst_no in reset", rst_no, 1'b0);
    chk("R1 drive in reset", pin_drive, 1'b1);
    rst_ni = 1'b1;
    steps(SF + T + NS + 4);
    chk("R4 power-up release", rst_o, 1'b0);

    // R3: short supply dip
    supply_ok = 1'b0; steps(SF - 1); supply_ok = 1'b1;
    for (int i = 0; i < 30; i++) begin steps(1); chk("R3 short dip ignored", rst_o, 1'b0); end

    // R2/R4: long supply dip
    supply_ok = 1'b0; steps(NS + SF);
    chk("R2 before assert", rst_o, 1'b0);
    steps(1); chk("R2 assert edge", rst_o, 1'b1);
    steps(8); chk("R4 held while low", rst_o, 1'b1);
    supply_ok = 1'b1; steps(NS - 1 + SF + T);
    chk("R4 last active edge", rst_o, 1'b1);
    steps(1); chk("R4 release edge", rst_o, 1'b0);

    // R6: short button press
    mr_n = 1'b0; steps(MF - 1); mr_n = 1'b1;
    for (int i = 0; i < 30; i++) begin steps(1); chk("R6 short press ignored", rst_o, 1'b0); end

    // R5: long press
    mr_n = 1'b0; steps(NS + MF);
    chk("R5 before assert", rst_o, 1'b0);
    steps(1); chk("R5 assert edge", rst_o, 1'b1);
    steps(60); chk("R5 held while pressed", rst_o, 1'b1);
    mr_n = 1'b1; steps(NS - 1 + MF + T);
    chk("R5 last active edge", rst_o, 1'b1);
    steps(1); chk("R5 release edge", rst_o, 1'b0);

    // R7/R8: short external pin pulse
    ext_low = 1'b1; steps(NS);
    chk("R7 before assert", rst_o, 1'b0);
    steps(1); chk("R7 assert edge", rst_o, 1'b1);
    ext_low = 1'b0;
    steps(T - 1); chk("R7 last active edge", rst_o, 1'b1);
    steps(1); chk("R7 release edge", rst_o, 1'b0);
    for (int i = 0; i < 3 * T; i++) begin steps(1); chk("R8 no self retrigger", rst_o, 1'b0); end

    // random mix
    s_run = 0; m_run = 0; idle_run = 1000; s_rem = 0; m_rem = 0; p_rem = 0;
    for (int c = 0; c < 4000; c++) begin
      steps(1);
      if (s_run >= NS + SF + 1) chk("R2 random supply hold", rst_o, 1'b1);
      if (m_run >= NS + MF + 1) chk("R5 random button hold", rst_o, 1'b1);
      e = exp_by_run(idle_run, NS + FMAX + T + 1, rst_o);
      if (idle_run >= NS + FMAX + T + 1) chk("R4 random idle release", rst_o, ~e);
      if (s_rem == 0 && $urandom_range(0, 59) == 0) s_rem = $urandom_range(1, 12);
      if (m_rem == 0 && $urandom_range(0, 59) == 0) m_rem = $urandom_range(1, 12);
      if (p_rem == 0 && $urandom_range(0, 79) == 0) p_rem = $urandom_range(1, 6);
      supply_ok = (s_rem == 0);
      mr_n      = (m_rem == 0);
      ext_low   = (p_rem != 0);
      if (s_rem > 0) s_rem--;
      if (m_rem > 0) m_rem--;
      if (p_rem > 0) p_rem--;
      s_run    = supply_ok ? 0 : s_run + 1;
      m_run    = mr_n ? 0 : m_run + 1;
      idle_run = (supply_ok && mr_n && !ext_low) ? idle_run + 1 : 0;
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule